// File: doc/BRIEF.md
# Battery Monitor Power-Mode Controller

This block chooses the operating mode of a battery-monitor measurement front end. There are four modes. Run converts on every 0.5 s tick. Sample converts at a slower programmable interval. Sample-Sleep turns the analog section off between single conversions spaced far apart. Shelf-Sleep stops all measurement and ignores the serial bus. The block asks the converter for work with a one-cycle start pulse. It then counts a conversion as outstanding until the converter returns a done pulse.

Mode decisions come from several sources: host control bits, trip enables, and comparisons of the pack voltage, auxiliary voltage and signed current readings against threshold inputs. A bus-idle detector watches both serial bus lines. Its counters are timed in 0.5 s ticks, and they decide when the pack may enter or leave Shelf-Sleep. All time in the block is counted in ticks from an external 0.5 s tick pulse.

Top module: `batt_pwr_mode_ctrl`

## Requirements
- R1: After synchronous reset the mode is Run (code 0). `conv_start`, `bus_ignore` and `vol_reset` are low, and `analog_en` is high. Mode codes are Run=0, Sample=1, Sample-Sleep=2, Shelf-Sleep=3.
- R2: In Run, every tick produces exactly one `conv_start` pulse, one cycle wide, in the cycle after the tick. A new start is withheld while a conversion is outstanding.
- R3: Run changes to Sample when `samp_en` is 1 and `vp_meas >= por_trip`. Sample returns to Run when `samp_en` clears or when the pack voltage drops below `por_trip`.
- R4: In Sample, starts are spaced 2^`samp_div` ticks apart. The first start comes on the 2^`samp_div`-th tick after the block enters the mode.
- R5: Run or Sample changes to Sample-Sleep when any entry trigger holds: `sslp_req`; `vp_ent` with `vp_meas < vp_trip`; `gp_ent` with `gp_meas < gp_trip`; `i_ent` with |`i_meas`| < `i_trip`. In this mode starts are spaced 2^(`samp_div`+`sslp_div`) ticks apart.
- R6: Sample-Sleep wakes to Run in three cases: when every entry trigger has gone; when `i_ex` is set and signed `i_meas > i_chg_trip`; or when `vp_ex` is set and `vp_meas > vp_wake_trip`. After a charge or voltage wake, re-entry is held off until every entry trigger has been false at least once.
- R7: `analog_en` is high in Run and Sample. In Sample-Sleep it is high only from `conv_start` until `conv_done`. In Shelf-Sleep it is low. `accum_en` pulses with every tick in every mode except Shelf-Sleep.
- R8: While a conversion is outstanding, the block makes no transition into or out of Sample-Sleep and no transition into Shelf-Sleep. The transition happens after `conv_done`.
- R9: Shelf-Sleep is armed by `shelf_req`, or by `sh_ent` together with `vp_meas < ss_trip`. Once armed, the block enters after both bus lines have been low for T_SHELF ticks, counted only after both lines were seen high. Any high level on either line restarts the count.
- R10: In Shelf-Sleep `conv_start`, `accum_en` and `analog_en` stay low and `bus_ignore` is high.
- R11: Shelf-Sleep exits to Run once both bus lines have stayed high for T_WAKE ticks. Any low level restarts the count. The exit produces a single one-cycle `vol_reset` pulse.
- R12: When several conditions hold at once, Shelf-Sleep wins over Sample-Sleep, and Sample-Sleep wins over Sample.
- R13: The current magnitude is the absolute value of the two's-complement reading, and the most negative code has magnitude 2^(MEAS_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse every 0.5 s |
| samp_en | input | 1 | Request Sample mode |
| sslp_req | input | 1 | Request Sample-Sleep |
| shelf_req | input | 1 | Arm Shelf-Sleep |
| vp_ent | input | 1 | Enable low pack voltage sleep trigger |
| gp_ent | input | 1 | Enable low auxiliary voltage sleep trigger |
| i_ent | input | 1 | Enable low current magnitude sleep trigger |
| i_ex | input | 1 | Enable charge current wake |
| vp_ex | input | 1 | Enable pack voltage wake |
| sh_ent | input | 1 | Arm Shelf-Sleep on low pack voltage |
| samp_div | input | DIV_W | Sample interval exponent |
| sslp_div | input | DIV_W | Extra Sample-Sleep interval exponent |
| vp_meas | input | MEAS_W | Pack voltage reading, unsigned |
| gp_meas | input | MEAS_W | Auxiliary voltage reading, unsigned |
| i_meas | input | MEAS_W | Current reading, signed, positive is charge |
| vp_trip | input | MEAS_W | Pack voltage sleep threshold |
| gp_trip | input | MEAS_W | Auxiliary voltage sleep threshold |
| i_trip | input | MEAS_W | Current magnitude sleep threshold, unsigned |
| i_chg_trip | input | MEAS_W | Charge wake threshold, signed |
| vp_wake_trip | input | MEAS_W | Pack voltage wake threshold |
| ss_trip | input | MEAS_W | Pack voltage shelf threshold |
| por_trip | input | MEAS_W | Minimum pack voltage for Sample |
| sda | input | 1 | Bus data line level |
| scl | input | 1 | Bus clock line level |
| conv_done | input | 1 | Conversion finished pulse |
| mode | output | 2 | Current mode code |
| conv_start | output | 1 | Conversion start pulse |
| analog_en | output | 1 | Analog section enable |
| accum_en | output | 1 | Accumulator update strobe |
| bus_ignore | output | 1 | Bus traffic to be ignored |
| vol_reset | output | 1 | Volatile state reset pulse |

## Verification
The mode changes one clock after the condition that causes it. A start pulse appears one clock after its tick, and `accum_en` appears in the same cycle as the tick. A deferred sleep transition lands two clocks after `conv_done`. The bus-idle counts are due on the T-th qualifying tick, and the mode follows one clock later. The bench drives each stimulus just after a falling edge. It then waits six cycles after each tick, which covers a complete start–done exchange. Counts of start, accumulate and reset pulses are read only after those quiet windows. Boundary cases set each threshold equal to its reading and glitch each bus line for one cycle.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

    typedef enum logic [1:0] {
        MODE_RUN    = 2'd0,
        MODE_SAMPLE = 2'd1,
        MODE_SSLEEP = 2'd2,
        MODE_SHELF  = 2'd3
    } pm_mode_e;

    // Decoded conditions handed from the comparators to the state machine.
    typedef struct packed {
        logic sample_ok;
        logic sslp_cond;
        logic wake_cond;
        logic shelf_arm;
    } pm_cond_t;

    function automatic logic mode_converts(pm_mode_e m);
        return m != MODE_SHELF;
    endfunction

    function automatic logic mode_awake(pm_mode_e m);
        return (m == MODE_RUN) || (m == MODE_SAMPLE);
    endfunction

endpackage

// File: rtl/bpm_interval_timer.sv
module bpm_interval_timer #(
    parameter int EXP_W = 4,
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             restart,
    input  logic             tick,
    input  logic [EXP_W-1:0] exp_sel,
    output logic             fire
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   span;
    logic [CNT_W:0]   cnt_inc;

    always_comb begin
        span    = (CNT_W+1)'(1) << exp_sel;
        cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
        fire    = en && tick && (cnt_inc >= span);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (en && tick) begin
            cnt_q <= fire ? '0 : cnt_inc[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/bpm_bus_idle.sv
module bpm_bus_idle #(
    parameter int T_SHELF = 4,
    parameter int T_WAKE  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic sda,
    input  logic scl,
    output logic shelf_ok,
    output logic wake_ok
);
    localparam int LW = $clog2(T_SHELF + 1);
    localparam int HW = $clog2(T_WAKE + 1);

    logic          seen_high_q;
    logic [LW-1:0] low_q;
    logic [HW-1:0] high_q;
    logic          both_low;
    logic          both_high;

    assign both_low  = !sda && !scl;
    assign both_high = sda && scl;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_high_q <= 1'b0;
            low_q       <= '0;
            high_q      <= '0;
        end else begin
            if (both_high) seen_high_q <= 1'b1;

            // the low count only starts after a high-to-low fall of both lines
            if (!both_low || !seen_high_q)
                low_q <= '0;
            else if (tick && (low_q != LW'(T_SHELF)))
                low_q <= low_q + LW'(1);

            if (!both_high)
                high_q <= '0;
            else if (tick && (high_q != HW'(T_WAKE)))
                high_q <= high_q + HW'(1);
        end
    end

    assign shelf_ok = (low_q == LW'(T_SHELF));
    assign wake_ok  = (high_q == HW'(T_WAKE));
endmodule

// File: rtl/bpm_mode_fsm.sv
module bpm_mode_fsm
    import bpm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     fire,
    input  logic     conv_done,
    input  pm_cond_t cond,
    input  logic     shelf_ok,
    input  logic     wake_ok,
    output pm_mode_e mode_q,
    output logic     restart,
    output logic     conv_start,
    output logic     busy,
    output logic     analog_en,
    output logic     accum_en,
    output logic     bus_ignore,
    output logic     vol_reset
);
    pm_mode_e mode_d;
    logic     busy_q, busy_d;
    logic     start_q, start_now;
    logic     hold_q, hold_d;
    logic     vreset_q;
    logic     quiet;
    logic     shelf_go;

    always_comb begin
        start_now = fire && !busy_q && mode_converts(mode_q);
        quiet     = !busy_q && !start_now;
        shelf_go  = cond.shelf_arm && shelf_ok && quiet;

        busy_d = busy_q;
        if (start_now)      busy_d = 1'b1;
        else if (conv_done) busy_d = 1'b0;

        mode_d = mode_q;
        hold_d = cond.sslp_cond ? hold_q : 1'b0;
        case (mode_q)
            MODE_SHELF: begin
                if (wake_ok) mode_d = MODE_RUN;
            end
            MODE_SSLEEP: begin
                if (shelf_go) begin
                    mode_d = MODE_SHELF;
                end else if (cond.wake_cond && quiet) begin
                    mode_d = MODE_RUN;
                    // woken while a trigger still holds: block re-entry
                    if (cond.sslp_cond) hold_d = 1'b1;
                end
            end
            MODE_RUN, MODE_SAMPLE: begin
                if (shelf_go)
                    mode_d = MODE_SHELF;
                else if (cond.sslp_cond && !hold_q && quiet)
                    mode_d = MODE_SSLEEP;
                else if (cond.sample_ok)
                    mode_d = MODE_SAMPLE;
                else
                    mode_d = MODE_RUN;
            end
            default: mode_d = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_RUN;
            busy_q   <= 1'b0;
            start_q  <= 1'b0;
            hold_q   <= 1'b0;
            vreset_q <= 1'b0;
        end else begin
            mode_q   <= mode_d;
            busy_q   <= busy_d;
            start_q  <= start_now;
            hold_q   <= hold_d;
            vreset_q <= (mode_q == MODE_SHELF) && (mode_d == MODE_RUN);
        end
    end

    assign restart    = (mode_d != mode_q);
    assign conv_start = start_q;
    assign busy       = busy_q;
    assign analog_en  = mode_awake(mode_q) || ((mode_q == MODE_SSLEEP) && busy_q);
    assign accum_en   = tick && mode_converts(mode_q);
    assign bus_ignore = (mode_q == MODE_SHELF);
    assign vol_reset  = vreset_q;
endmodule

// File: rtl/batt_pwr_mode_ctrl.sv
module batt_pwr_mode_ctrl
    import bpm_pkg::*;
#(
    parameter int MEAS_W  = 16,
    parameter int DIV_W   = 3,
    parameter int T_SHELF = 4,
    parameter int T_WAKE  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              samp_en,
    input  logic              sslp_req,
    input  logic              shelf_req,
    input  logic              vp_ent,
    input  logic              gp_ent,
    input  logic              i_ent,
    input  logic              i_ex,
    input  logic              vp_ex,
    input  logic              sh_ent,
    input  logic [DIV_W-1:0]  samp_div,
    input  logic [DIV_W-1:0]  sslp_div,
    input  logic [MEAS_W-1:0] vp_meas,
    input  logic [MEAS_W-1:0] gp_meas,
    input  logic [MEAS_W-1:0] i_meas,
    input  logic [MEAS_W-1:0] vp_trip,
    input  logic [MEAS_W-1:0] gp_trip,
    input  logic [MEAS_W-1:0] i_trip,
    input  logic [MEAS_W-1:0] i_chg_trip,
    input  logic [MEAS_W-1:0] vp_wake_trip,
    input  logic [MEAS_W-1:0] ss_trip,
    input  logic [MEAS_W-1:0] por_trip,
    input  logic              sda,
    input  logic              scl,
    input  logic              conv_done,
    output logic [1:0]        mode,
    output logic              conv_start,
    output logic              analog_en,
    output logic              accum_en,
    output logic              bus_ignore,
    output logic              vol_reset
);
    localparam int EXP_W = DIV_W + 1;
    localparam int CNT_W = 2 * ((1 << DIV_W) - 1);

    pm_cond_t          cond;
    pm_mode_e          mode_w;
    logic [MEAS_W-1:0] i_mag;
    logic [EXP_W-1:0]  exp_sel;
    logic              fire, restart, shelf_ok, wake_ok, conv_busy;
    logic              trig_any;

    // two's-complement magnitude; the most negative code maps to 2^(MEAS_W-1)
    assign i_mag = i_meas[MEAS_W-1] ? (~i_meas + MEAS_W'(1)) : i_meas;

    always_comb begin
        trig_any = sslp_req
                 || (vp_ent && (vp_meas < vp_trip))
                 || (gp_ent && (gp_meas < gp_trip))
                 || (i_ent  && (i_mag < i_trip));
        cond.sslp_cond = trig_any;
        cond.wake_cond = !trig_any
                 || (i_ex  && ($signed(i_meas) > $signed(i_chg_trip)))
                 || (vp_ex && (vp_meas > vp_wake_trip));
        cond.shelf_arm = shelf_req || (sh_ent && (vp_meas < ss_trip));
        cond.sample_ok = samp_en && (vp_meas >= por_trip);
    end

    always_comb begin
        case (mode_w)
            MODE_SAMPLE: exp_sel = EXP_W'(samp_div);
            MODE_SSLEEP: exp_sel = EXP_W'(samp_div) + EXP_W'(sslp_div);
            default:     exp_sel = '0;
        endcase
    end

    bpm_interval_timer #(.EXP_W(EXP_W), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .en(mode_converts(mode_w)), .restart(restart),
        .tick(tick), .exp_sel(exp_sel), .fire(fire)
    );

    bpm_bus_idle #(.T_SHELF(T_SHELF), .T_WAKE(T_WAKE)) u_idle (
        .clk(clk), .rst(rst), .tick(tick), .sda(sda), .scl(scl),
        .shelf_ok(shelf_ok), .wake_ok(wake_ok)
    );

    bpm_mode_fsm u_fsm (
        .clk(clk), .rst(rst), .tick(tick), .fire(fire), .conv_done(conv_done),
        .cond(cond), .shelf_ok(shelf_ok), .wake_ok(wake_ok),
        .mode_q(mode_w), .restart(restart), .conv_start(conv_start),
        .busy(conv_busy), .analog_en(analog_en), .accum_en(accum_en),
        .bus_ignore(bus_ignore), .vol_reset(vol_reset)
    );

    assign mode = mode_w;
endmodule

// File: rtl/bpm_chk.sv
module bpm_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       conv_start,
    input logic       analog_en,
    input logic       accum_en,
    input logic       bus_ignore,
    input logic       vol_reset,
    input logic       busy
);
    // R10
    shelf_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd3) |-> (!conv_start && !analog_en && !accum_en && bus_ignore));

    // R11
    vol_reset_src_chk: assert property (@(posedge clk) disable iff (rst)
        vol_reset |-> (mode == 2'd0 && $past(mode) == 2'd3));

    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    // R8
    defer_chk: assert property (@(posedge clk) disable iff (rst)
        ((mode != $past(mode)) && (mode == 2'd2 || mode == 2'd3 || $past(mode) == 2'd2))
        |-> !$past(busy));

    // R7
    sleep_analog_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2 && !busy) |-> !analog_en);
endmodule

bind batt_pwr_mode_ctrl bpm_chk u_chk (
    .clk(clk), .rst(rst), .mode(mode), .conv_start(conv_start),
    .analog_en(analog_en), .accum_en(accum_en), .bus_ignore(bus_ignore),
    .vol_reset(vol_reset), .busy(conv_busy)
);

// File: tb/sim_batt_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_batt_pwr_mode_ctrl;
    localparam int TS = 4;
    localparam int TW = 3;

    logic clk = 0, rst = 1, tick = 0;
    logic samp_en = 0, sslp_req = 0, shelf_req = 0, vp_ent = 0, gp_ent = 0, i_ent = 0;
    logic i_ex = 0, vp_ex = 0, sh_ent = 0;
    logic [2:0] samp_div = 0, sslp_div = 0;
    logic [15:0] vp_meas = 3000, gp_meas = 1000, i_meas = 100;
    logic [15:0] vp_trip = 2800, gp_trip = 500, i_trip = 20, i_chg_trip = 200;
    logic [15:0] vp_wake_trip = 3500, ss_trip = 2600, por_trip = 2500;
    logic sda = 1, scl = 1;
    logic resp_done = 0, man_done = 0, auto_done = 1;
    logic conv_done;
    logic [1:0] mode;
    logic conv_start, analog_en, accum_en, bus_ignore, vol_reset;

    int vectors = 0, miscompares = 0;
    int n_start = 0, n_acc = 0, n_vr = 0;

    assign conv_done = resp_done | man_done;

    always #4 clk = ~clk;

    batt_pwr_mode_ctrl #(.T_SHELF(TS), .T_WAKE(TW)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .samp_en(samp_en), .sslp_req(sslp_req),
        .shelf_req(shelf_req), .vp_ent(vp_ent), .gp_ent(gp_ent), .i_ent(i_ent),
        .i_ex(i_ex), .vp_ex(vp_ex), .sh_ent(sh_ent), .samp_div(samp_div),
        .sslp_div(sslp_div), .vp_meas(vp_meas), .gp_meas(gp_meas), .i_meas(i_meas),
        .vp_trip(vp_trip), .gp_trip(gp_trip), .i_trip(i_trip), .i_chg_trip(i_chg_trip),
        .vp_wake_trip(vp_wake_trip), .ss_trip(ss_trip), .por_trip(por_trip),
        .sda(sda), .scl(scl), .conv_done(conv_done), .mode(mode),
        .conv_start(conv_start), .analog_en(analog_en), .accum_en(accum_en),
        .bus_ignore(bus_ignore), .vol_reset(vol_reset)
    );

    always @(posedge clk) begin
        if (conv_start) n_start <= n_start + 1;
        if (accum_en)   n_acc   <= n_acc + 1;
        if (vol_reset)  n_vr    <= n_vr + 1;
    end

    // converter model: answers a start two falling edges later
    initial begin
        forever begin
            @(negedge clk);
            if (conv_start && auto_done) begin
                @(negedge clk); resp_done = 1;
                @(negedge clk); resp_done = 0;
            end
        end
    end

    function automatic int expect_starts(int ticks, int expo);
        return ticks / (1 << expo);
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_tick(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1;
            @(negedge clk); tick = 0;
            step(6);
        end
    endtask

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_counts();
        @(negedge clk);
        n_start = 0; n_acc = 0; n_vr = 0;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors++; miscompares++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        step(5); rst = 0; step(2);

        // R1 reset state
        chk("R1 mode", mode, 0);
        chk("R1 conv_start", conv_start, 0);
        chk("R1 bus_ignore", bus_ignore, 0);
        chk("R1 vol_reset", vol_reset, 0);
        chk("R1 analog_en", analog_en, 1);

        // R2 one start per tick in Run, R7 accumulate strobes
        clear_counts(); do_tick(4);
        chk("R2 run starts", n_start, 4);
        chk("R7 run accum", n_acc, 4);

        // R3 entry gated by power-on threshold
        samp_en = 1; vp_meas = 2499; step(3);
        chk("R3 below por stays run", mode, 0);
        vp_meas = 2500; step(3);
        chk("R3 sample entry", mode, 1);
        chk("R7 sample analog", analog_en, 1);

        // R4 random sample intervals
        for (int it = 0; it < 3; it++) begin
            int d;
            d = $urandom_range(0, 4);
            samp_en = 0; step(3); samp_div = 3'(d); samp_en = 1; step(3);
            clear_counts();
            if (d > 0) begin
                do_tick((1 << d) - 1);
                chk("R4 before first", n_start, 0);
            end
            do_tick(1);
            chk("R4 first start", n_start, 1);
            do_tick(2 * (1 << d));
            chk("R4 spaced starts", n_start, 1 + expect_starts(2 * (1 << d), d));
        end
        vp_meas = 3000;
        samp_en = 0; step(3);
        chk("R3 sample exit", mode, 0);

        // R5 sleep interval 2^(1+2) ticks, R7 analog off between samples
        samp_div = 1; sslp_div = 2;
        sslp_req = 1; step(3);
        chk("R5 sslp entry", mode, 2);
        chk("R7 sleep analog off", analog_en, 0);
        clear_counts(); do_tick(7);
        chk("R5 sleep before first", n_start, 0);
        do_tick(1);
        chk("R5 sleep first", n_start, 1);
        chk("R7 sleep accum", n_acc, 8);
        do_tick(8);
        chk("R5 sleep second", n_start, 2);
        sslp_req = 0; step(3);
        chk("R6 wake on clear", mode, 0);

        // R5 each threshold trigger, with random values
        for (int k = 0; k < 4; k++) begin
            case (k)
                0: begin vp_ent = 1; vp_meas = 16'(2799 - $urandom_range(0, 99)); end
                1: begin gp_ent = 1; gp_meas = 16'($urandom_range(0, 499)); end
                2: begin i_ent = 1; i_meas = 16'(-$urandom_range(0, 19)); end
                default: sslp_req = 1;
            endcase
            step(3);
            chk("R5 trigger entry", mode, 2);
            vp_ent = 0; gp_ent = 0; i_ent = 0; sslp_req = 0;
            vp_meas = 3000; gp_meas = 1000; i_meas = 100;
            step(3);
            chk("R5 trigger removed", mode, 0);
        end

        // R5 threshold boundaries: equal is not below
        vp_ent = 1; vp_meas = 2800; step(3);
        chk("R5 vp equal no entry", mode, 0);
        vp_ent = 0; vp_meas = 3000;
        i_ent = 1; i_meas = 16'(-20); step(3);
        chk("R13 magnitude equal no entry", mode, 0);

        // R13 most negative code
        i_trip = 16'hFFFF; i_meas = 16'h8000; step(3);
        chk("R13 min code enters", mode, 2);
        i_ent = 0; step(3);
        i_trip = 16'h8000; i_ent = 1; step(3);
        chk("R13 min code equal trip", mode, 0);
        i_ent = 0; i_trip = 20; i_meas = 100; step(3);

        // R6 charge wake and re-entry hold-off
        sslp_req = 1; step(3);
        i_ex = 1; i_meas = 200; step(3);
        chk("R6 charge equal stays", mode, 2);
        i_meas = 201; step(3);
        chk("R6 charge wake", mode, 0);
        i_ex = 0; i_meas = 100; step(5);
        chk("R6 hold-off", mode, 0);
        sslp_req = 0; step(3); sslp_req = 1; step(3);
        chk("R6 re-entry after release", mode, 2);

        // R6 voltage wake
        vp_ex = 1; vp_meas = 3500; step(3);
        chk("R6 vp equal stays", mode, 2);
        vp_meas = 3501; step(3);
        chk("R6 vp wake", mode, 0);
        vp_ex = 0; vp_meas = 3000; sslp_req = 0; step(3);

        // R8 sleep entry waits for the outstanding conversion
        auto_done = 0;
        do_tick(1);
        sslp_req = 1; step(5);
        chk("R8 deferred", mode, 0);
        man_done = 1; step(1); man_done = 0; step(3);
        chk("R8 after done", mode, 2);
        auto_done = 1;

        // R12 sleep over sample
        samp_en = 1; step(3);
        chk("R12 sleep over sample", mode, 2);

        // R9 shelf entry after bus idle, with a glitch
        shelf_req = 1; sda = 0; scl = 0;
        do_tick(TS - 1);
        chk("R9 idle short", mode, 2);
        scl = 1; step(1); scl = 0;
        do_tick(TS - 1);
        chk("R9 glitch restarts", mode, 2);
        do_tick(1);
        chk("R12 shelf over sleep", mode, 3);

        // R10 shelf is quiet
        clear_counts(); do_tick(3);
        chk("R10 no starts", n_start, 0);
        chk("R10 no accum", n_acc, 0);
        chk("R10 bus_ignore", bus_ignore, 1);
        chk("R10 analog off", analog_en, 0);

        // R11 wake after bus active for T_WAKE ticks
        shelf_req = 0; sslp_req = 0; samp_en = 0;
        sda = 1; scl = 1;
        do_tick(TW - 1);
        chk("R11 wake short", mode, 3);
        sda = 0; step(1); sda = 1;
        do_tick(TW - 1);
        chk("R11 glitch restarts", mode, 3);
        do_tick(1);
        chk("R11 wake to run", mode, 0);
        chk("R11 one vol_reset", n_vr, 1);

        // R9 arming on low pack voltage
        sh_ent = 1; vp_meas = 2600; sda = 0; scl = 0;
        do_tick(TS);
        chk("R9 vp equal not armed", mode, 0);
        vp_meas = 2599; step(3);
        chk("R9 vp armed shelf", mode, 3);
        sh_ent = 0; sda = 1; scl = 1;
        do_tick(TW);
        chk("R11 second wake", mode, 0);

        finish_run();
    end
endmodule